// File: doc/BRIEF.md
# Vector Shape Setup Decoder

This block turns one shape-setup instruction into the register writes that set up a remapped vector loop. The instruction carries an x extent `xd`, a stride field `zd`, a 4-bit schedule mode and a vertical-first flag. Each legal mode has a template for up to three 32-bit shape words, and the decoder produces those words. It also produces the length fields of the vector state: the vector length, the maximum length and the vertical-first bit.

The words are built from mode-specific templates. A template is copied from shape word 0 into words 1 and 2, and each copy gets its own small patch. Two modes need a vector length that takes more than one cycle to find. The first sums a halving iteration count over the low bits of `xd`. The second counts the operations of a pairwise reduction tree. A shared stage engine handles both, at one stage per cycle. The maximum length comes last, from the vector length and the stride scale `zd+1`.

The decoder is used one instruction at a time. Software-facing logic pulses `start_i` while `busy_o` is low. The decoder answers with a single `done_o` cycle, and every register write for that instruction is strobed in that same cycle.

Top module: `shp_cfg_decoder`

## Requirements
- R1: After reset `busy_o`, `done_o`, `illegal_o`, `st_we_o` and all of `shp_we_o` are low.
- R2: Bit positions are counted with word bit 0 as the most significant bit. Every written shape word carries `xd`, zero-extended to 6 bits, in bits 0:5. It carries `zd`, zero-extended to 6 bits, in bits 12:17, except where a rule below clears that field.
- R3: Butterfly modes 0100, 1100 and 1011 set bits 6:11 of word 0 to 000010. Mode 1011 sets bits 30:31=11, 18:20=011 and 21:23=101. The other two modes set 30:31=01 and 18:20=100. Word 1 is word 0 with 28:29=01. Word 2 is word 0 with 12:17 cleared. All three words are written.
- R4: Coefficient modes 0101 and 1101 set word 0 bits 30:31=01 and 6:11=000100. Mode 0101 also sets 21:23=001. Words 1 and 2 are copies of word 0 with bits 28:29 set to 10 and 11 respectively. All three words are written.
- R5: For the butterfly and coefficient modes, the length is computed as follows. Start with a count of (xd+1)>>1 and a sum of 0. Visit the bits of `xd` from the least significant bit upward, at most 5 of them. Stop at the first zero bit. For each one bit, add the count to the sum and then halve the count.
- R6: Half-swap modes 0110, 1110 and 1111 write word 0 only. Bits 6:11 are 000101, and the length is xd+1. Mode 1110 sets 18:20=001. Mode 1111 sets 30:31=01. The other two modes set 30:31=11.
- R7: Reduction mode 0111 writes words 0 and 1. Word 0 has 30:31=10, and word 1 is word 0 with 28:29=01. The length is the number of pair operations in a tree reduction of N=xd+1 elements, using strides 1, 2, 4 and so on.
- R8: `st_len_o` is the length. `st_maxlen_o` is the low 7 bits of length×(zd+1). `st_vf_o` repeats the vertical-first bit of the instruction.
- R9: Modes 0000-0011, 1000, 1001 and 1010 give one `done_o` cycle with `illegal_o` high and no write strobe.
- R10: All strobes of a legal instruction are high in the single cycle where `done_o` is high. `done_o` never lasts two cycles.
- R11: `busy_o` rises the cycle after an accepted start and is low again when `done_o` is high. A start while busy is ignored. Done follows start within 12 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Instruction strobe, taken only while idle |
| mode_i | input | 4 | Schedule mode |
| xd_i | input | 5 | x extent field (extent minus one) |
| zd_i | input | 5 | Stride field (scale minus one) |
| vf_i | input | 1 | Vertical-first flag |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Mode not decodable, valid with done |
| shp_we_o | output | 3 | Write strobes of shape words 2..0 |
| shp0_o | output | 32 | Shape word 0 data |
| shp1_o | output | 32 | Shape word 1 data |
| shp2_o | output | 32 | Shape word 2 data |
| st_we_o | output | 1 | Vector state length-field write strobe |
| st_maxlen_o | output | 7 | Maximum length |
| st_len_o | output | 7 | Vector length |
| st_vf_o | output | 1 | Vertical-first bit |

## Verification
The bench builds the decoder with its default widths: a 5-bit `xd`, a 5-bit `zd` and a 7-bit length. At these widths every legal mode can be swept across all 32 values of `xd`. The sweep covers the early stop of the stage sum at each bit position, the tree counts for odd and even N, and the full five-stage run at xd=31. With `zd` at 31, the product length×(zd+1) goes past 7 bits, so the truncation of the maximum length is exercised. Random instructions over all 16 modes are mixed in. Separate directed runs inject a second start while the decoder is busy.

// File: rtl/shp_pkg.sv
// Package: shared constants and types for the shape setup decoder.
// Assumes 32-bit shape words. Field offsets below are LSB-based indices of
// fields that the downstream index generators decode.
package shp_pkg;

    localparam int SHP_W     = 32;
    localparam int FIELD6_W  = 6;

    // LSB-based low index of each shape word field
    localparam int F_XD_LO    = 26;  // extent, word bits 0:5
    localparam int F_SUB_LO   = 20;  // sub-mode, word bits 6:11
    localparam int F_ZD_LO    = 14;  // stride, word bits 12:17
    localparam int F_OUTER_LO = 11;  // outer sub-mode, word bits 18:20
    localparam int F_INV_LO   = 8;   // inversion, word bits 21:23
    localparam int F_SCHED_LO = 2;   // schedule select, word bits 28:29
    localparam int F_KIND_LO  = 0;   // kind, word bits 30:31

    localparam logic [3:0] M_BFLY_A  = 4'b0100;
    localparam logic [3:0] M_BFLY_B  = 4'b1100;
    localparam logic [3:0] M_BFLY_I  = 4'b1011;
    localparam logic [3:0] M_COEF_A  = 4'b0101;
    localparam logic [3:0] M_COEF_B  = 4'b1101;
    localparam logic [3:0] M_HSW_A   = 4'b0110;
    localparam logic [3:0] M_HSW_B   = 4'b1110;
    localparam logic [3:0] M_HSW_F   = 4'b1111;
    localparam logic [3:0] M_TREE    = 4'b0111;

    typedef enum logic [1:0] {
        LEN_DIRECT = 2'd0,
        LEN_LOGSUM = 2'd1,
        LEN_TREE   = 2'd2
    } len_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RUN   = 2'd2,
        ST_SCALE = 2'd3
    } dec_state_e;

endpackage

// File: rtl/shp_template.sv
// Module: shp_template
// Builds the three shape words, the write mask and the length method for a
// mode. Purely combinational. Assumes XD_W and ZD_W are at most 6.
module shp_template
    import shp_pkg::*;
#(
    parameter int XD_W = 5,
    parameter int ZD_W = 5
) (
    input  logic [3:0]       mode,
    input  logic [XD_W-1:0]  xd,
    input  logic [ZD_W-1:0]  zd,
    output logic [SHP_W-1:0] w0,
    output logic [SHP_W-1:0] w1,
    output logic [SHP_W-1:0] w2,
    output logic [2:0]       we,
    output len_kind_e        kind,
    output logic             legal
);

    logic [SHP_W-1:0] base;

    // Purpose: common part of every word (extent and stride fields).
    always_comb begin
        base = '0;
        base[F_XD_LO +: FIELD6_W] = FIELD6_W'(xd);
        base[F_ZD_LO +: FIELD6_W] = FIELD6_W'(zd);
    end

    // Purpose: mode-specific template for word 0 plus patched copies.
    always_comb begin
        w0    = base;
        w1    = base;
        w2    = base;
        we    = 3'b000;
        kind  = LEN_DIRECT;
        legal = 1'b1;
        case (mode)
            M_BFLY_A, M_BFLY_B, M_BFLY_I: begin
                w0[F_SUB_LO +: 6] = 6'b000010;
                if (mode == M_BFLY_I) begin
                    w0[F_KIND_LO +: 2]  = 2'b11;
                    w0[F_OUTER_LO +: 3] = 3'b011;
                    w0[F_INV_LO +: 3]   = 3'b101;
                end else begin
                    w0[F_KIND_LO +: 2]  = 2'b01;
                    w0[F_OUTER_LO +: 3] = 3'b100;
                end
                w1 = w0;
                w1[F_SCHED_LO +: 2] = 2'b01;
                w2 = w0;
                w2[F_ZD_LO +: FIELD6_W] = '0;
                we   = 3'b111;
                kind = LEN_LOGSUM;
            end
            M_COEF_A, M_COEF_B: begin
                w0[F_KIND_LO +: 2] = 2'b01;
                w0[F_SUB_LO +: 6]  = 6'b000100;
                if (mode == M_COEF_A) begin
                    w0[F_INV_LO +: 3] = 3'b001;
                end
                w1 = w0;
                w1[F_SCHED_LO +: 2] = 2'b10;
                w2 = w0;
                w2[F_SCHED_LO +: 2] = 2'b11;
                we   = 3'b111;
                kind = LEN_LOGSUM;
            end
            M_HSW_A, M_HSW_B, M_HSW_F: begin
                w0[F_SUB_LO +: 6] = 6'b000101;
                if (mode == M_HSW_B) begin
                    w0[F_OUTER_LO +: 3] = 3'b001;
                end
                w0[F_KIND_LO +: 2] = (mode == M_HSW_F) ? 2'b01 : 2'b11;
                we   = 3'b001;
                kind = LEN_DIRECT;
            end
            M_TREE: begin
                w0[F_KIND_LO +: 2] = 2'b10;
                w1 = w0;
                w1[F_SCHED_LO +: 2] = 2'b01;
                we   = 3'b011;
                kind = LEN_TREE;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/shp_len_engine.sv
// Module: shp_len_engine
// Computes the vector length one stage per cycle: a halving stage sum,
// a tree operation count, or the plain extent. Pulses fin in the cycle
// when len is final. Assumes VL_W >= XD_W + 2.
module shp_len_engine
    import shp_pkg::*;
#(
    parameter int XD_W = 5,
    parameter int VL_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  len_kind_e       kind_i,
    input  logic [XD_W-1:0] xd_i,
    output logic            fin,
    output logic [VL_W-1:0] len
);

    localparam int STAGE_W = $clog2(XD_W + 1);
    localparam int AW      = VL_W + 1;

    logic               active;
    len_kind_e          kind_q;
    logic [XD_W-1:0]    xd_q;
    logic [STAGE_W-1:0] stage;
    logic [VL_W-1:0]    acc;
    logic [VL_W-1:0]    icnt;

    logic [AW-1:0]      n_elems;
    logic [AW-1:0]      step;
    logic [AW-1:0]      tree_ops;
    logic               xd_bit;
    logic               stop;
    logic [VL_W-1:0]    add;

    // Purpose: per-stage stop decision and increment for the active method.
    always_comb begin
        n_elems  = AW'(xd_q) + AW'(1);
        step     = AW'(1) << stage;
        tree_ops = ((n_elems - step - AW'(1)) >> (stage + STAGE_W'(1))) + AW'(1);
        xd_bit   = (int'(stage) < XD_W) ? xd_q[stage] : 1'b0;
        case (kind_q)
            LEN_LOGSUM: begin
                stop = !xd_bit;
                add  = icnt;
            end
            LEN_TREE: begin
                stop = (step >= n_elems);
                add  = tree_ops[VL_W-1:0];
            end
            default: begin
                stop = 1'b1;
                add  = '0;
            end
        endcase
    end

    assign fin = active && stop;
    assign len = acc;

    // Purpose: stage sequencing and accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            kind_q <= LEN_DIRECT;
            xd_q   <= '0;
            stage  <= '0;
            acc    <= '0;
            icnt   <= '0;
        end else if (go) begin
            active <= 1'b1;
            kind_q <= kind_i;
            xd_q   <= xd_i;
            stage  <= '0;
            acc    <= (kind_i == LEN_DIRECT) ? VL_W'(xd_i) + VL_W'(1) : '0;
            icnt   <= (VL_W'(xd_i) + VL_W'(1)) >> 1;
        end else if (active) begin
            if (stop) begin
                active <= 1'b0;
            end else begin
                acc   <= acc + add;
                icnt  <= icnt >> 1;
                stage <= stage + STAGE_W'(1);
            end
        end
    end

endmodule

// File: rtl/shp_scale.sv
// Module: shp_scale
// Maximum length = low VL_W bits of length * (zd + 1). Combinational.
module shp_scale #(
    parameter int VL_W = 7,
    parameter int ZD_W = 5
) (
    input  logic [VL_W-1:0] len,
    input  logic [ZD_W-1:0] zd,
    output logic [VL_W-1:0] maxlen
);

    localparam int PW = VL_W + ZD_W + 1;

    logic [PW-1:0] prod;

    // Purpose: form the product wide, then keep the low bits.
    always_comb begin
        prod   = PW'(len) * (PW'(zd) + PW'(1));
        maxlen = prod[VL_W-1:0];
    end

endmodule

// File: rtl/shp_cfg_decoder.sv
// Module: shp_cfg_decoder (top)
// Accepts one shape-setup instruction while idle, builds the shape words,
// runs the length engine, scales to the maximum length and commits all
// writes in one done cycle. Illegal modes end with done+illegal, no writes.
module shp_cfg_decoder
    import shp_pkg::*;
#(
    parameter int XD_W = 5,
    parameter int ZD_W = 5,
    parameter int VL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       mode_i,
    input  logic [XD_W-1:0]  xd_i,
    input  logic [ZD_W-1:0]  zd_i,
    input  logic             vf_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             illegal_o,
    output logic [2:0]       shp_we_o,
    output logic [31:0]      shp0_o,
    output logic [31:0]      shp1_o,
    output logic [31:0]      shp2_o,
    output logic             st_we_o,
    output logic [VL_W-1:0]  st_maxlen_o,
    output logic [VL_W-1:0]  st_len_o,
    output logic             st_vf_o
);

    dec_state_e        state;
    logic [3:0]        mode_q;
    logic [XD_W-1:0]   xd_q;
    logic [ZD_W-1:0]   zd_q;
    logic              vf_q;
    logic [VL_W-1:0]   len_q;

    logic [SHP_W-1:0]  t_w0, t_w1, t_w2;
    logic [2:0]        t_we;
    len_kind_e         t_kind;
    logic              t_legal;
    logic              eng_go, eng_fin;
    logic [VL_W-1:0]   eng_len;
    logic [VL_W-1:0]   scaled;

    shp_template #(.XD_W(XD_W), .ZD_W(ZD_W)) u_tpl (
        .mode  (mode_q),
        .xd    (xd_q),
        .zd    (zd_q),
        .w0    (t_w0),
        .w1    (t_w1),
        .w2    (t_w2),
        .we    (t_we),
        .kind  (t_kind),
        .legal (t_legal)
    );

    assign eng_go = (state == ST_CHECK) && t_legal;

    shp_len_engine #(.XD_W(XD_W), .VL_W(VL_W)) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (eng_go),
        .kind_i (t_kind),
        .xd_i   (xd_q),
        .fin    (eng_fin),
        .len    (eng_len)
    );

    shp_scale #(.VL_W(VL_W), .ZD_W(ZD_W)) u_scale (
        .len    (len_q),
        .zd     (zd_q),
        .maxlen (scaled)
    );

    assign busy_o = (state != ST_IDLE);

    // Purpose: instruction sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (start_i) state <= ST_CHECK;
                ST_CHECK: state <= t_legal ? ST_RUN : ST_IDLE;
                ST_RUN:   if (eng_fin) state <= ST_SCALE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: capture instruction fields on accept and length on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            xd_q   <= '0;
            zd_q   <= '0;
            vf_q   <= 1'b0;
            len_q  <= '0;
        end else begin
            if (state == ST_IDLE && start_i) begin
                mode_q <= mode_i;
                xd_q   <= xd_i;
                zd_q   <= zd_i;
                vf_q   <= vf_i;
            end
            if (state == ST_RUN && eng_fin) begin
                len_q <= eng_len;
            end
        end
    end

    // Purpose: registered commit of all writes in the single done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            illegal_o   <= 1'b0;
            shp_we_o    <= '0;
            st_we_o     <= 1'b0;
            shp0_o      <= '0;
            shp1_o      <= '0;
            shp2_o      <= '0;
            st_maxlen_o <= '0;
            st_len_o    <= '0;
            st_vf_o     <= 1'b0;
        end else begin
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
            shp_we_o  <= '0;
            st_we_o   <= 1'b0;
            if (state == ST_CHECK && !t_legal) begin
                done_o    <= 1'b1;
                illegal_o <= 1'b1;
            end
            if (state == ST_SCALE) begin
                done_o      <= 1'b1;
                shp_we_o    <= t_we;
                st_we_o     <= 1'b1;
                shp0_o      <= t_w0;
                shp1_o      <= t_w1;
                shp2_o      <= t_w2;
                st_maxlen_o <= scaled;
                st_len_o    <= len_q;
                st_vf_o     <= vf_q;
            end
        end
    end

endmodule

// File: rtl/shp_cfg_checker.sv
// Module: shp_cfg_checker
// Port-level properties of shp_cfg_decoder, bound to every instance.
module shp_cfg_checker #(
    parameter int XD_W    = 5,
    parameter int ZD_W    = 5,
    parameter int VL_W    = 7,
    parameter int LAT_MAX = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [3:0]      mode_i,
    input logic [XD_W-1:0] xd_i,
    input logic [ZD_W-1:0] zd_i,
    input logic            vf_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            illegal_o,
    input logic [2:0]      shp_we_o,
    input logic [31:0]     shp0_o,
    input logic [31:0]     shp1_o,
    input logic [31:0]     shp2_o,
    input logic            st_we_o,
    input logic [VL_W-1:0] st_maxlen_o,
    input logic [VL_W-1:0] st_len_o,
    input logic            st_vf_o
);

    localparam int PW = VL_W + 7;

    logic [7:0]    busy_run;
    logic [PW-1:0] exp_prod;

    // Purpose: length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_run <= '0;
        else if (busy_o) busy_run <= busy_run + 8'd1;
        else             busy_run <= '0;
    end

    // Purpose: expected product from the written stride field and length.
    always_comb begin
        exp_prod = PW'(st_len_o) * (PW'(shp0_o[19:14]) + PW'(1));
    end

    a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    a_r11_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 8'(LAT_MAX));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_strobe_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((|shp_we_o) || st_we_o) |-> done_o);
    a_r10_commit_all: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !illegal_o) |-> (st_we_o && shp_we_o[0]));
    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && shp_we_o == 3'b000 && !st_we_o));
    a_r8_maxlen: assert property (@(posedge clk) disable iff (!rst_n)
        st_we_o |-> (st_maxlen_o == exp_prod[VL_W-1:0]));
    a_r2_copy_extent: assert property (@(posedge clk) disable iff (!rst_n)
        shp_we_o[1] |-> (shp1_o[31:26] == shp0_o[31:26]));

endmodule

bind shp_cfg_decoder shp_cfg_checker #(
    .XD_W (XD_W),
    .ZD_W (ZD_W),
    .VL_W (VL_W)
) u_shp_chk (.*);

// File: tb/tb_shp_cfg_decoder.sv
// Bench: directed sweeps and seeded random instructions against models.
module tb_shp_cfg_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [4:0]  xd_i = '0;
    logic [4:0]  zd_i = '0;
    logic        vf_i = 1'b0;
    logic        busy_o, done_o, illegal_o, st_we_o, st_vf_o;
    logic [2:0]  shp_we_o;
    logic [31:0] shp0_o, shp1_o, shp2_o;
    logic [6:0]  st_maxlen_o, st_len_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    shp_cfg_decoder dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .xd_i(xd_i), .zd_i(zd_i), .vf_i(vf_i), .busy_o(busy_o),
        .done_o(done_o), .illegal_o(illegal_o), .shp_we_o(shp_we_o),
        .shp0_o(shp0_o), .shp1_o(shp1_o), .shp2_o(shp2_o),
        .st_we_o(st_we_o), .st_maxlen_o(st_maxlen_o),
        .st_len_o(st_len_o), .st_vf_o(st_vf_o)
    );

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // field writer, word bit 0 = most significant
    function automatic logic [31:0] put(input logic [31:0] r, input int a, input int b, input int v);
        for (int k = a; k <= b; k++) r[31-k] = 1'((v >> (b - k)) & 1);
        return r;
    endfunction

    function automatic bit is_bfly(input int m);
        return (m == 4 || m == 12 || m == 11);
    endfunction
    function automatic bit is_coef(input int m);
        return (m == 5 || m == 13);
    endfunction
    function automatic bit is_hsw(input int m);
        return (m == 6 || m == 14 || m == 15);
    endfunction

    function automatic logic [2:0] exp_we(input int m);
        if (is_bfly(m) || is_coef(m)) return 3'b111;
        if (is_hsw(m)) return 3'b001;
        if (m == 7) return 3'b011;
        return 3'b000;
    endfunction

    function automatic int exp_len(input int m, input int xd);
        int vlen = 0, ic, n = 0, step = 1, j;
        bit go = 1;
        if (is_hsw(m)) return xd + 1;
        if (m == 7) begin
            while (step < xd + 1) begin
                j = 0;
                while (j + step < xd + 1) begin j += 2 * step; vlen++; end
                step = 2 * step;
            end
            return vlen;
        end
        ic = (xd + 1) >> 1;
        while (go && n < 5) begin
            if (((xd >> n) & 1) == 0) go = 0;
            else begin vlen += ic; ic = ic >> 1; n++; end
        end
        return vlen;
    endfunction

    function automatic logic [31:0] exp_word(input int m, input int xd, input int zd, input int idx);
        logic [31:0] r0, r1, r2;
        r0 = put(put(32'h0, 0, 5, xd), 12, 17, zd);
        r1 = r0; r2 = r0;
        if (is_bfly(m)) begin
            r0 = put(r0, 6, 11, 2);
            if (m == 11) begin
                r0 = put(put(put(r0, 30, 31, 3), 18, 20, 3), 21, 23, 5);
            end else begin
                r0 = put(put(r0, 30, 31, 1), 18, 20, 4);
            end
            r1 = put(r0, 28, 29, 1);
            r2 = put(r0, 12, 17, 0);
        end else if (is_coef(m)) begin
            r0 = put(put(r0, 30, 31, 1), 6, 11, 4);
            if (m == 5) r0 = put(r0, 21, 23, 1);
            r1 = put(r0, 28, 29, 2);
            r2 = put(r0, 28, 29, 3);
        end else if (is_hsw(m)) begin
            r0 = put(r0, 6, 11, 5);
            if (m == 14) r0 = put(r0, 18, 20, 1);
            r0 = put(r0, 30, 31, (m == 15) ? 1 : 3);
        end else if (m == 7) begin
            r0 = put(r0, 30, 31, 2);
            r1 = put(r0, 28, 29, 1);
        end
        return (idx == 0) ? r0 : (idx == 1) ? r1 : r2;
    endfunction

    function automatic string req_of(input int m);
        if (is_bfly(m)) return "R3";
        if (is_coef(m)) return "R4";
        if (is_hsw(m)) return "R6";
        if (m == 7) return "R7";
        return "R9";
    endfunction

    // one instruction; optionally a second start while busy (must be ignored)
    task automatic run_one(input int m, input int xd, input int zd, input bit vf, input bit inject);
        int wait_n = 0;
        int len_e;
        logic [2:0] we_e;
        @(negedge clk);
        start_i = 1'b1; mode_i = 4'(m); xd_i = 5'(xd); zd_i = 5'(zd); vf_i = vf;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R11 busy after start", 64'(busy_o), 64'd1);
        if (inject) begin
            start_i = 1'b1; mode_i = 4'd5; xd_i = 5'd3; zd_i = 5'd7; vf_i = ~vf;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o && wait_n < 20) begin
            @(negedge clk);
            wait_n++;
        end
        chk(done_o == 1'b1 && wait_n <= 11, "R11 done latency", 64'(wait_n), 64'd11);
        chk(busy_o == 1'b0, "R11 idle at done", 64'(busy_o), 64'd0);
        we_e = exp_we(m);
        if (we_e == 3'b000) begin
            chk(illegal_o && shp_we_o == 3'b000 && !st_we_o, "R9 illegal no writes",
                64'({illegal_o, shp_we_o, st_we_o}), 64'b10000);
        end else begin
            len_e = exp_len(m, xd);
            chk(!illegal_o && shp_we_o == we_e && st_we_o, "R10 strobes together",
                64'({illegal_o, shp_we_o, st_we_o}), 64'({1'b0, we_e, 1'b1}));
            chk(shp0_o == exp_word(m, xd, zd, 0), {req_of(m), " R2 word0"}, 64'(shp0_o), 64'(exp_word(m, xd, zd, 0)));
            if (we_e[1])
                chk(shp1_o == exp_word(m, xd, zd, 1), {req_of(m), " word1"}, 64'(shp1_o), 64'(exp_word(m, xd, zd, 1)));
            if (we_e[2])
                chk(shp2_o == exp_word(m, xd, zd, 2), {req_of(m), " word2"}, 64'(shp2_o), 64'(exp_word(m, xd, zd, 2)));
            chk(int'(st_len_o) == len_e, (m == 7) ? "R7 length" : is_hsw(m) ? "R6 length" : "R5 length",
                64'(st_len_o), 64'(len_e));
            chk(int'(st_maxlen_o) == ((len_e * (zd + 1)) % 128) && st_vf_o == vf, "R8 maxlen and vf",
                64'({st_vf_o, st_maxlen_o}), 64'({vf, 7'((len_e * (zd + 1)) % 128)}));
        end
        @(negedge clk);
        chk(done_o == 1'b0 && shp_we_o == 3'b000 && !st_we_o, "R10 single done cycle",
            64'({done_o, shp_we_o, st_we_o}), 64'd0);
        if (inject) begin
            wait_n = 0;
            for (int k = 0; k < 14; k++) begin
                @(negedge clk);
                if (done_o || busy_o) wait_n++;
            end
            chk(wait_n == 0, "R11 start while busy ignored", 64'(wait_n), 64'd0);
        end
    endtask

    initial begin
        int legal_modes [9] = '{4, 12, 11, 5, 13, 6, 14, 15, 7};
        int bad_modes [7] = '{0, 1, 2, 3, 8, 9, 10};
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !illegal_o && shp_we_o == 3'b000 && !st_we_o, "R1 reset state",
            64'({busy_o, done_o, illegal_o, shp_we_o, st_we_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o, "R1 idle after reset", 64'({busy_o, done_o}), 64'd0);

        // directed corners: zero extent, full extent, stride overflow
        run_one(5, 0, 0, 1'b0, 1'b0);
        run_one(5, 31, 31, 1'b1, 1'b0);
        run_one(7, 31, 31, 1'b0, 1'b0);
        run_one(11, 7, 3, 1'b1, 1'b0);
        run_one(15, 31, 31, 1'b1, 1'b0);
        run_one(7, 20, 2, 1'b0, 1'b1);
        run_one(4, 15, 1, 1'b1, 1'b1);
        foreach (bad_modes[i]) run_one(bad_modes[i], 9, 4, 1'b1, 1'b0);

        // every legal mode across every extent
        foreach (legal_modes[i]) begin
            for (int x = 0; x < 32; x++) begin
                run_one(legal_modes[i], x, int'($urandom % 32), 1'($urandom), 1'b0);
            end
        end

        // random instructions over all modes
        for (int k = 0; k < 200; k++) begin
            run_one(int'($urandom % 16), int'($urandom % 32), int'($urandom % 32), 1'($urandom), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule